// File: doc/BRIEF.md
# Periodic Tick Timer with Missed-Period Count

This block produces the steady time base that an operating-system scheduler runs on. The input clock passes through a fixed divide-by-16 stage. The divided rate drives an interval counter that returns to zero each time it reaches a programmed period. Each return to zero adds one to an elapsed-period counter. Software that is slow to service the interrupt can therefore find out how many periods went by, and no tick is lost.

Software reaches the block through a small register port with four word addresses. The first is a mode register that holds the period, a run bit and an interrupt-enable bit. The second is a status word that carries the pending flag. The third is a value word: reading it returns both counters, clears the elapsed-period count and acknowledges the interrupt. The fourth is an image word that returns the same fields with no side effect. The single interrupt output is a level. It stays high while a period is pending and interrupts are enabled.

Top module: `tick_timer`

## Requirements
- R1: After reset, all four addresses read zero and `irq` is low.
- R2: While running, the interval count (bits 19:0 of the value and image words) increases by one every 16 clock cycles.
- R3: When a divided tick arrives with the interval count equal to the period, the count returns to zero. Successive wraps are therefore 16*(period+1) cycles apart.
- R4: Each wrap adds one to the elapsed-period count (bits 31:20 of the value and image words). The count saturates at 4095.
- R5: A read of address 2 (value word) returns {elapsed count, interval count}. It then clears the elapsed count and the pending flag.
- R6: When a wrap coincides with a value-word read, the read returns the pre-wrap fields. Afterwards the elapsed count is 1 and the pending flag stays set.
- R7: A read of address 3 (image word) returns the same fields as the value word and changes neither the counts nor the pending flag.
- R8: The pending flag (address 1, bit 0) sets on every wrap and holds until a value-word read.
- R9: `irq` is high exactly when the pending flag is set and the interrupt-enable bit (mode bit 25) is 1.
- R10: Setting the run bit (mode bit 24) starts counting. Clearing it lets the count continue to the next wrap, after which the count stays at zero and no further wraps occur.
- R11: Address 0 reads back the period in bits 19:0, the run bit in bit 24 and the interrupt enable in bit 25, with all other bits zero. Writes to addresses other than 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe; side effects apply on the clock edge |
| bus_addr | input | 2 | Word address: 0 mode, 1 status, 2 value, 3 image |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The timer is run with a short period (3) to measure the wrap-to-wrap distance and the per-16-cycle step. A zero period makes every divided tick a wrap, which allows a read to be placed on the same edge as a wrap and lets saturation be reached quickly. A run with several unserviced periods shows the difference between a counter that accumulates and a plain flag. Interleaved image and value reads show which access has side effects. Clearing the run bit partway through a period shows whether the block stops immediately or only at the next wrap.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DEF_CNT_W = 20;
  localparam int unsigned DEF_OVF_W = 12;
  localparam int unsigned DEF_PRE_W = 4;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_STAT  = 2'd1,
    REG_VALUE = 2'd2,
    REG_IMAGE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign tick = run & (&div_q);
endmodule

// File: rtl/tt_interval.sv
module tt_interval #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] limit);
    return (cur >= limit) ? '0 : cur + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= step(cnt_q, period);
  end

  assign count = cnt_q;
  assign wrap  = tick & (cnt_q >= period);
endmodule

// File: rtl/tt_overflow.sv
module tt_overflow #(
  parameter int unsigned OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             ack,
  output logic [OVF_W-1:0] ovf,
  output logic             pend
);
  function automatic logic [OVF_W-1:0] next_ovf(input logic [OVF_W-1:0] cur,
                                                input logic clr, input logic inc);
    logic [OVF_W-1:0] base;
    base = clr ? '0 : cur;
    if (inc && !(&base)) base = base + 1'b1;
    return base;
  endfunction

  logic [OVF_W-1:0] ovf_q;
  logic             pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ovf_q <= next_ovf(ovf_q, ack, wrap);
      if (wrap)     pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end

  assign ovf  = ovf_q;
  assign pend = pend_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W,
  parameter int unsigned OVF_W = DEF_OVF_W,
  parameter int unsigned PRE_W = DEF_PRE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [1:0]             bus_addr,
  input  logic [CNT_W+OVF_W-1:0] bus_wdata,
  output logic [CNT_W+OVF_W-1:0] bus_rdata,
  output logic                   irq
);
  localparam int unsigned DATA_W = CNT_W + OVF_W;
  localparam int unsigned EN_POS = CNT_W + 4;
  localparam int unsigned IE_POS = EN_POS + 1;

  logic [CNT_W-1:0] period_q;
  logic             en_q;
  logic             ie_q;
  logic             run_q;

  logic             tick_w;
  logic             wrap_w;
  logic             val_rd_w;
  logic             running_w;
  logic             ie_w;
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OVF_W-1:0] ovf_q;
  logic             mode_wr_w;

  assign mode_wr_w = bus_wr && (bus_addr == REG_MODE);
  assign val_rd_w  = bus_rd && (bus_addr == REG_VALUE);
  assign running_w = en_q | run_q;
  assign ie_w      = ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      en_q     <= 1'b0;
      ie_q     <= 1'b0;
    end else if (mode_wr_w) begin
      period_q <= bus_wdata[CNT_W-1:0];
      en_q     <= bus_wdata[EN_POS];
      ie_q     <= bus_wdata[IE_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= 1'b0;
    else if (en_q)   run_q <= 1'b1;
    else if (wrap_w) run_q <= 1'b0;
  end

  tt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running_w), .tick(tick_w)
  );

  tt_interval #(.CNT_W(CNT_W)) u_int (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .period(period_q),
    .count(cnt_q), .wrap(wrap_w)
  );

  tt_overflow #(.OVF_W(OVF_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .ack(val_rd_w),
    .ovf(ovf_q), .pend(pend_q)
  );

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:IE_POS+1], bus_wdata[EN_POS-1:CNT_W]};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_MODE: begin
        bus_rdata[CNT_W-1:0] = period_q;
        bus_rdata[EN_POS]    = en_q;
        bus_rdata[IE_POS]    = ie_q;
      end
      REG_STAT:  bus_rdata[0] = pend_q;
      default:   bus_rdata = {ovf_q, cnt_q};
    endcase
  end

  assign irq = pend_q & ie_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned OVF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             wrap,
  input logic             val_rd,
  input logic             running,
  input logic             pend,
  input logic             ie,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [OVF_W-1:0] ovf
);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt == $past(cnt) + 1'b1);

  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ovf) && !val_rd) |=> (&ovf));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (val_rd && !wrap) |=> (ovf == '0) && !pend);

  p_ack_with_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (val_rd && wrap) |=> (ovf == OVF_W'(1)) && pend);

  p_wrap_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> pend);

  p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && ie));

  p_stopped_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(cnt));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .wrap(wrap_w), .val_rd(val_rd_w),
  .running(running_w), .pend(pend_q), .ie(ie_w), .irq(irq), .cnt(cnt_q), .ovf(ovf_q)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h0100_0000;
  localparam logic [31:0] IE = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    skip(3);
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_irq(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    for (int a = 0; a < 4; a++) begin
      peek(a[1:0], d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    do_reset();
    bus_write(2'd0, 32'hFFFF_FFFF);
    peek(2'd0, d);
    check("R11 mode readback", d, 32'h030F_FFFF);
    bus_write(2'd1, 32'h0001_2345);
    bus_write(2'd3, 32'h0000_0000);
    peek(2'd0, d);
    check("R11 non-mode write ignored", d, 32'h030F_FFFF);
  endtask

  task automatic t_period();
    logic [31:0] d;
    bit seen;
    int c0;
    do_reset();
    bus_write(2'd0, IE | EN | 32'd3);
    wait_irq(200, seen);
    check("R8 first wrap raises irq", {31'b0, seen}, 32'h1);
    c0 = cyc;
    bus_read(2'd3, d);
    check("R7 image after one wrap", d, 32'h0010_0000);
    check("R7 image keeps irq", {31'b0, irq}, 32'h1);
    bus_read(2'd1, d);
    check("R8 status pending", d, 32'h1);
    bus_read(2'd2, d);
    check("R5 value word fields", d, 32'h0010_0000);
    check("R5 irq cleared", {31'b0, irq}, 32'h0);
    peek(2'd3, d);
    check("R5 elapsed cleared", d, 32'h0);
    peek(2'd1, d);
    check("R8 status cleared by value read", d, 32'h0);
    wait_irq(200, seen);
    check("R3 wrap spacing 16*(P+1)", cyc - c0, 32'd64);
    skip(16);
    peek(2'd3, d);
    check("R2 count after 16 cycles", d & 32'h000F_FFFF, 32'd1);
  endtask

  task automatic t_missed();
    logic [31:0] d;
    bit seen;
    do_reset();
    bus_write(2'd0, IE | EN | 32'd3);
    wait_irq(200, seen);
    bus_read(2'd2, d);
    skip(295);
    peek(2'd3, d);
    check("R4 four missed periods, R2 count 2", d, 32'h0040_0002);
  endtask

  task automatic t_coincide();
    logic [31:0] d;
    bit seen;
    do_reset();
    bus_write(2'd0, IE | EN);
    wait_irq(100, seen);
    bus_read(2'd2, d);
    check("R5 value read P=0", d, 32'h0010_0000);
    skip(14);
    bus_read(2'd2, d);
    check("R6 read at wrap returns pre-wrap", d, 32'h0);
    peek(2'd3, d);
    check("R6 wrap counted after clear", d, 32'h0010_0000);
    check("R6 pending kept", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_sat();
    logic [31:0] d;
    do_reset();
    bus_write(2'd0, EN);
    skip(4200 * 16);
    peek(2'd3, d);
    check("R4 saturates at 4095", d >> 20, 32'hFFF);
    bus_read(2'd2, d);
    check("R4 value read saturated", d >> 20, 32'hFFF);
    peek(2'd3, d);
    check("R5 cleared after saturation", {31'b0, (d >> 20) < 2}, 32'h1);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    bit found;
    do_reset();
    bus_write(2'd0, EN | 32'd1);
    found = 1'b0;
    for (int i = 0; i < 100 && !found; i++) begin
      bus_read(2'd1, d);
      if (d[0]) found = 1'b1;
    end
    check("R8 pending without irq enable", {31'b0, found}, 32'h1);
    check("R9 irq gated off", {31'b0, irq}, 32'h0);
    bus_write(2'd0, IE | EN | 32'd1);
    check("R9 irq after enable", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    bit seen;
    do_reset();
    bus_write(2'd0, IE | EN | 32'd3);
    wait_irq(200, seen);
    bus_read(2'd2, d);
    bus_write(2'd0, IE | 32'd3);
    skip(38);
    peek(2'd3, d);
    check("R10 runs on to wrap", d, 32'h0000_0002);
    skip(100);
    peek(2'd3, d);
    check("R10 stopped at zero after wrap", d, 32'h0010_0000);
    skip(300);
    peek(2'd3, d);
    check("R10 no further wraps", d, 32'h0010_0000);
    check("R10 pending from last wrap", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_mode();
    t_period();
    t_missed();
    t_coincide();
    t_gate();
    t_stop();
    t_sat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule